// File: doc/BRIEF.md
# Interrupt Enable and Arbitration Controller

This block sits next to a small 8-bit processor core and decides when the core should take an interrupt. It serves three sources: an external pin event, a timer overflow and an A/D conversion-complete event. Each source arrives as a one-cycle event pulse from logic outside the block. The pulse sets a request flag. The flag then stays pending until it is serviced or cleared.

All control state lives in one 8-bit register on a simple register bus. Writes carry a per-bit mask, so single-bit set and clear operations reach exactly one field. The register holds three kinds of field:

- a master enable;
- one enable per source;
- one request flag per source.

When the master enable is set and at least one enabled flag is pending, the block chooses the highest-priority source. It then emits a one-cycle request strobe to the core together with a vector index. On the same edge it clears that source's flag and the master enable, so interrupts cannot nest. Only a return-from-interrupt pulse from the core sets the master enable again. The block saves no status and holds no stack: any context saving is left to software.

Top module: `irq_enable_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and `irq_req_o` is 0.
- R2: The register layout is fixed. Bit 0 is the master enable. Bits 1, 2 and 3 are the external, timer and A/D enables. Bits 4, 5 and 6 are the external, timer and A/D request flags. Bit 7 always reads 0. A write changes only the bits set in `wmask_i`.
- R3: An `evt_i` pulse on source k (bit 0 external, bit 1 timer, bit 2 A/D) sets flag k one edge later. The flag stays set while its enable or the master enable is 0.
- R4: A masked software write of 0 to a flag bit clears that flag. A masked write of 1 to a flag bit has no effect.
- R5: While the master enable is 0, `irq_req_o` stays 0, even when enabled flags are pending.
- R6: Suppose the register shows the master enable, an enable and the matching flag all set. Then `irq_req_o` is high for exactly one cycle, starting on the next clock edge.
- R7: On the edge that raises `irq_req_o`, the master enable and the flag of the taken source are cleared. The other flags keep their values.
- R8: Priority is external over timer over A/D. `irq_vec_o` is 0, 1 or 2 for those sources and is valid while `irq_req_o` is high.
- R9: A `reti_i` pulse sets the master enable on the next edge.
- R10: When a source is taken on the same edge as a software write of 1 to the master enable bit, the master enable ends up 0.
- R11: If an event pulse for a source arrives on the edge where that source is taken, its flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register bus select |
| we_i | input | 1 | Write enable (with sel_i) |
| addr_i | input | ADDR_W | Register address, decoded against REG_ADDR |
| wmask_i | input | DATA_W | Per-bit write mask |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, register value when selected at REG_ADDR, else 0 |
| evt_i | input | N_SRC | One-cycle event pulse per source |
| reti_i | input | 1 | Return-from-interrupt pulse from the core |
| irq_req_o | output | 1 | One-cycle interrupt request strobe |
| irq_vec_o | output | VEC_W | Vector index of the taken source |

## Verification
The bench uses the default build: three sources, an 8-bit register and a 4-bit address matched at 0x3. These are the values under which the register layout in R2 is fully populated. They also bring every pairing of two or three pending sources within reach of the priority checks. At these widths the bench can drive same-edge collisions directly: a take against a software master write, and a take against a fresh event.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int MEN_POS = 0;
  localparam int EN_POS  = 1;

  function automatic int flg_pos(input int n_src);
    return EN_POS + n_src;
  endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 3,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [VEC_W-1:0] idx_o,
  output logic [N_SRC-1:0] oh_o
);
  assign any_o = |req_i;
  assign oh_o  = req_i & ~(req_i - N_SRC'(1));

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = VEC_W'(i);
    end
  end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N_SRC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] en_mask_i,
  input  logic [N_SRC-1:0] en_data_i,
  input  logic [N_SRC-1:0] flg_mask_i,
  input  logic [N_SRC-1:0] flg_data_i,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             take_i,
  input  logic [N_SRC-1:0] take_oh_i,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] flg_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic en_q, flg_q, sw_clr, hw_clr;

    assign sw_clr = wr_i & flg_mask_i[g] & ~flg_data_i[g];
    assign hw_clr = take_i & take_oh_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else if (wr_i && en_mask_i[g]) en_q <= en_data_i[g];
    end

    // a new event outranks any clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flg_q <= 1'b0;
      else if (evt_i[g]) flg_q <= 1'b1;
      else if (sw_clr || hw_clr) flg_q <= 1'b0;
    end

    assign en_o[g]  = en_q;
    assign flg_o[g] = flg_q;
  end
endmodule

// File: rtl/irq_master_en.sv
module irq_master_en (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic reti_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic men_o
);
  logic men_q;

  // hardware clear > return > software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) men_q <= 1'b0;
    else if (take_i) men_q <= 1'b0;
    else if (reti_i) men_q <= 1'b1;
    else if (wr_i) men_q <= wbit_i;
  end

  assign men_o = men_q;
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC  = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h3,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wmask_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              reti_i,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  localparam int FLG_LSB = flg_pos(N_SRC);
  localparam int TOP_BIT = FLG_LSB + N_SRC;

  logic             hit_c, wr_c, men_q, any_c, take_c, req_q;
  logic [N_SRC-1:0] en_q, flg_q, pend_c, oh_c;
  logic [VEC_W-1:0] idx_c, vec_q;
  logic [DATA_W-1:0] reg_c;
  logic unused_bits;

  assign hit_c  = sel_i && (addr_i == REG_ADDR);
  assign wr_c   = hit_c && we_i;
  assign pend_c = flg_q & en_q;
  assign take_c = men_q & any_c;
  assign unused_bits = ^{wmask_i[DATA_W-1:TOP_BIT], wdata_i[DATA_W-1:TOP_BIT]};

  irq_master_en u_men (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take_c),
    .reti_i (reti_i),
    .wr_i   (wr_c && wmask_i[MEN_POS]),
    .wbit_i (wdata_i[MEN_POS]),
    .men_o  (men_q)
  );

  irq_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_c),
    .en_mask_i  (wmask_i[FLG_LSB-1:EN_POS]),
    .en_data_i  (wdata_i[FLG_LSB-1:EN_POS]),
    .flg_mask_i (wmask_i[TOP_BIT-1:FLG_LSB]),
    .flg_data_i (wdata_i[TOP_BIT-1:FLG_LSB]),
    .evt_i      (evt_i),
    .take_i     (take_c),
    .take_oh_i  (oh_c),
    .en_o       (en_q),
    .flg_o      (flg_q)
  );

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .req_i (pend_c),
    .any_o (any_c),
    .idx_o (idx_c),
    .oh_o  (oh_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= take_c;
      if (take_c) vec_q <= idx_c;
    end
  end

  always_comb begin
    reg_c = '0;
    reg_c[MEN_POS] = men_q;
    reg_c[FLG_LSB-1:EN_POS] = en_q;
    reg_c[TOP_BIT-1:FLG_LSB] = flg_q;
  end

  assign rdata_o   = hit_c ? reg_c : '0;
  assign irq_req_o = req_q;
  assign irq_vec_o = vec_q;
endmodule

// File: rtl/irq_enable_ctrl_chk.sv
module irq_enable_ctrl_chk #(
  parameter int N_SRC = 3,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             men_q,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] flg,
  input logic [N_SRC-1:0] evt_i,
  input logic             reti_i,
  input logic             take
);
  logic [N_SRC-1:0] pend_d, evt_d, lower_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_d <= '0;
      evt_d  <= '0;
    end else begin
      pend_d <= pend;
      evt_d  <= evt_i;
    end
  end

  assign lower_m = (N_SRC'(1) << vec_o) - N_SRC'(1);

  p_no_req_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !men_q |=> !req_o);

  p_req_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  p_men_clr_on_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !men_q);

  p_flag_clr_on_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !evt_d[vec_o]) |-> !flg[vec_o]);

  p_prio_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (pend_d[vec_o] && ((pend_d & lower_m) == '0)));

  p_reti_sets_men_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take) |=> men_q);

  p_take_beats_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !men_q);
endmodule

bind irq_enable_ctrl irq_enable_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_o  (irq_req_o),
  .vec_o  (irq_vec_o),
  .men_q  (men_q),
  .pend   (pend_c),
  .flg    (flg_q),
  .evt_i  (evt_i),
  .reti_i (reti_i),
  .take   (take_c)
);

// File: tb/irq_enable_ctrl_tb.sv
module irq_enable_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam logic [3:0] RA = 4'h3;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       sel_i = 0, we_i = 0, reti_i = 0;
  logic [3:0] addr_i = RA;
  logic [7:0] wmask_i = '0, wdata_i = '0, rdata_o;
  logic [2:0] evt_i = '0;
  logic       irq_req_o;
  logic [1:0] irq_vec_o;
  int n_vec = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_enable_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i),
    .wmask_i(wmask_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i),
    .reti_i(reti_i), .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] m, input logic [7:0] d);
    sel_i = 1; we_i = 1; addr_i = RA; wmask_i = m; wdata_i = d;
    tick();
    sel_i = 0; we_i = 0; wmask_i = '0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    sel_i = 1; we_i = 0; addr_i = RA;
    #1;
    chk(tag, 32'(rdata_o), 32'(exp));
    sel_i = 0;
  endtask

  task automatic ev(input logic [2:0] v);
    evt_i = v;
    tick();
    evt_i = '0;
  endtask

  task automatic reti();
    reti_i = 1;
    tick();
    reti_i = 0;
  endtask

  task automatic req_is(input logic r, input logic [1:0] v, input string tag);
    chk({tag, " req"}, 32'(irq_req_o), 32'(r));
    if (r) chk({tag, " vec"}, 32'(irq_vec_o), 32'(v));
  endtask

  task automatic t_reset();
    rd(8'h00, "R1 reg after reset");
    req_is(0, 0, "R1");
  endtask

  task automatic t_layout();
    wr(8'h0E, 8'h0A);
    rd(8'h0A, "R2 masked enable write");
    wr(8'h02, 8'h00);
    rd(8'h08, "R2 single-bit clear");
    wr(8'h70, 8'h70);
    rd(8'h08, "R4 flag write-1 ignored");
    wr(8'h80, 8'h80);
    rd(8'h08, "R2 bit7 reads 0");
    wr(8'hFF, 8'h00);
    rd(8'h00, "R2 clear all");
  endtask

  task automatic t_pending();
    wr(8'h0E, 8'h0E);
    ev(3'b010);
    rd(8'h2E, "R3 timer flag set");
    for (int i = 0; i < 3; i++) begin
      req_is(0, 0, "R5 master off");
      tick();
    end
    rd(8'h2E, "R3 flag held pending");
    wr(8'h20, 8'h00);
    rd(8'h0E, "R4 software clear");
  endtask

  task automatic t_service();
    ev(3'b100);
    rd(8'h4E, "R3 adc flag");
    wr(8'h01, 8'h01);
    rd(8'h4F, "R6 all set");
    req_is(0, 0, "R6 not yet");
    tick();
    req_is(1, 2, "R6 strobe adc");
    rd(8'h0E, "R7 master and flag cleared");
    tick();
    req_is(0, 0, "R6 single cycle");
    reti();
    rd(8'h0F, "R9 reti sets master");
  endtask

  task automatic t_enable_gate();
    wr(8'h0F, 8'h0D);
    ev(3'b001);
    rd(8'h1D, "R3 ext flag with enable off");
    req_is(0, 0, "R3 gated");
    tick();
    req_is(0, 0, "R3 still gated");
    wr(8'h02, 8'h02);
    rd(8'h1F, "R3 enable on");
    tick();
    req_is(1, 0, "R3 serviced after enable");
    rd(8'h0E, "R7 ext taken");
    tick();
    reti();
    rd(8'h0F, "R9 reti");
  endtask

  task automatic t_priority();
    ev(3'b111);
    rd(8'h7F, "R3 all flags");
    tick();
    req_is(1, 0, "R8 ext first");
    rd(8'h6E, "R7 others kept");
    tick();
    req_is(0, 0, "R5 after take");
    reti();
    rd(8'h6F, "R9 reti");
    tick();
    req_is(1, 1, "R8 timer second");
    rd(8'h4E, "R7 timer taken");
    tick();
    reti();
    tick();
    req_is(1, 2, "R8 adc last");
    rd(8'h0E, "R7 adc taken");
    tick();
    reti();
    rd(8'h0F, "R9 reti");
  endtask

  task automatic t_hw_beats_sw();
    ev(3'b010);
    rd(8'h2F, "R10 timer pending");
    wr(8'h01, 8'h01);
    req_is(1, 1, "R10 take");
    rd(8'h0E, "R10 hw clear wins");
    reti();
    rd(8'h0F, "R9 reti");
  endtask

  task automatic t_evt_during_take();
    ev(3'b001);
    ev(3'b001);
    req_is(1, 0, "R11 take");
    rd(8'h1E, "R11 flag kept by new event");
    tick();
    req_is(0, 0, "R11 single");
    reti();
    rd(8'h1F, "R11 still pending");
    tick();
    req_is(1, 0, "R11 serviced again");
    rd(8'h0E, "R11 flag cleared");
    tick();
    reti();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_pending();
    t_service();
    t_enable_gate();
    t_priority();
    t_hw_beats_sw();
    t_evt_during_take();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule